// File: doc/BRIEF.md
# PWM Compare Channel with External Clear

This block is one compare channel of an up-counting timer. It compares the shared counter value with the channel's compare value and produces a registered raw reference level. A mode field selects frozen, two PWM polarities, or a constant low or high level. The counter, its prescaler and the downstream polarity and output-enable stages are outside this block.

The compare value is double-buffered. The compare input is sampled only in the cycle that carries the overflow pulse, and it is used for comparisons from that cycle on. A change on the compare input during a period therefore never alters the current period.

An external clear level, gated by an enable bit, can pull the reference low in the frozen and PWM modes. Once pulled low, the reference stays low until the next overflow, even if the clear level drops. After that overflow it follows the comparison again. In the two constant-level modes, the clear has no effect.

Top module: `pwm_cmp_chan`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `ref_o` is 0 and the active compare value is 0.
- R2: In mode 3'b001 (PWM A), `ref_o` becomes 1 on the edge after a cycle in which `cnt_i` < active compare, and 0 otherwise.
- R3: In mode 3'b010 (PWM B), `ref_o` is the inverse of R2: it is 1 when `cnt_i` >= active compare.
- R4: Mode 3'b011 drives `ref_o` to 0 and mode 3'b100 drives it to 1, on the next edge.
- R5: Mode 3'b000 (frozen), and the unused codes 3'b101 to 3'b111, hold `ref_o` at its current value.
- R6: When `clr_en_i`=1 and `ext_clr_i`=1 in mode 3'b000, 3'b001 or 3'b010, `ref_o` is 0 on the next edge, whatever the comparison gives.
- R7: Once cleared, `ref_o` stays 0 until the overflow cycle, even after `ext_clr_i` falls. In the overflow cycle it follows the comparison again, unless the clear is still requested.
- R8: With `clr_en_i`=0, `ext_clr_i` has no effect on `ref_o`.
- R9: In modes 3'b011 and 3'b100, the clear input has no effect, and no held clear state is left behind.
- R10: The active compare value is loaded from `cmp_i` only in a cycle with `ovf_i`=1, and it already applies to that cycle's comparison. A change on `cmp_i` during a period leaves that period unchanged.
- R11: In PWM A, a compare value of 0 keeps `ref_o` at 0. A compare value above the counter's maximum keeps `ref_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W | Shared counter value |
| ovf_i | input | 1 | Overflow pulse, high in the cycle where the counter shows 0 |
| cmp_i | input | CNT_W | Preload compare value |
| mode_i | input | 3 | Channel mode |
| clr_en_i | input | 1 | Enables the external clear |
| ext_clr_i | input | 1 | External clear level |
| ref_o | output | 1 | Registered raw reference |

## Verification
The main function is driven by a counter of period 10, with compare values in the middle of the range, at 0, and above the maximum. These runs separate a correct strict less-than from an off-by-one, and PWM A from PWM B. Clear pulses are placed mid-period and again across an overflow. These show the difference between a level that only follows the clear input and a state that is held until overflow. The clear is also raised with the enable off and in the constant-level modes, to show that it is gated. A compare change in mid-period shows whether the double buffer keeps the current period intact.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
  typedef enum logic [2:0] {
    MODE_FRZ  = 3'b000,
    MODE_PWMA = 3'b001,
    MODE_PWMB = 3'b010,
    MODE_FLO  = 3'b011,
    MODE_FHI  = 3'b100
  } chmode_e;

  // Frozen and both PWM modes accept the external clear.
  function automatic logic mode_clearable(input logic [2:0] m);
    return (m == MODE_FRZ) || (m == MODE_PWMA) || (m == MODE_PWMB);
  endfunction
endpackage

// File: rtl/cmp_shadow.sv
module cmp_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ovf,
  input  logic [CNT_W-1:0] cmp_in,
  output logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] cmp_eff
);
  always_ff @(posedge clk) begin
    if (rst)      cmp_act <= '0;
    else if (ovf) cmp_act <= cmp_in;
  end

  // The overflow cycle already compares against the newly loaded value.
  always_comb cmp_eff = ovf ? cmp_in : cmp_act;
endmodule

// File: rtl/ref_level_sel.sv
module ref_level_sel
  import pwm_cmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_eff,
  input  logic             ref_now,
  output logic             raw_next,
  output logic             clearable
);
  logic below;

  always_comb begin
    below     = (cnt < cmp_eff);
    clearable = mode_clearable(mode);
    case (chmode_e'(mode))
      MODE_PWMA: raw_next = below;
      MODE_PWMB: raw_next = ~below;
      MODE_FLO:  raw_next = 1'b0;
      MODE_FHI:  raw_next = 1'b1;
      default:   raw_next = ref_now;
    endcase
  end
endmodule

// File: rtl/clr_hold.sv
module clr_hold (
  input  logic clk,
  input  logic rst,
  input  logic ovf,
  input  logic clr_req,
  output logic held
);
  always_ff @(posedge clk) begin
    if (rst)          held <= 1'b0;
    else if (clr_req) held <= 1'b1;
    else if (ovf)     held <= 1'b0;
  end
endmodule

// File: rtl/pwm_cmp_chan.sv
module pwm_cmp_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovf_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [2:0]       mode_i,
  input  logic             clr_en_i,
  input  logic             ext_clr_i,
  output logic             ref_o
);
  logic [CNT_W-1:0] cmp_act;
  logic [CNT_W-1:0] cmp_eff;
  logic             raw_next;
  logic             clearable;
  logic             clr_req;
  logic             held;
  logic             ref_q;

  cmp_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst(rst), .ovf(ovf_i), .cmp_in(cmp_i),
    .cmp_act(cmp_act), .cmp_eff(cmp_eff)
  );

  ref_level_sel #(.CNT_W(CNT_W)) u_sel (
    .mode(mode_i), .cnt(cnt_i), .cmp_eff(cmp_eff), .ref_now(ref_q),
    .raw_next(raw_next), .clearable(clearable)
  );

  always_comb clr_req = clr_en_i & ext_clr_i & clearable;

  clr_hold u_hold (
    .clk(clk), .rst(rst), .ovf(ovf_i), .clr_req(clr_req), .held(held)
  );

  always_ff @(posedge clk) begin
    if (rst)                                     ref_q <= 1'b0;
    else if (clearable && (clr_req || (held && !ovf_i))) ref_q <= 1'b0;
    else                                         ref_q <= raw_next;
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/pwm_cmp_chan_chk.sv
module pwm_cmp_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ovf_i,
  input logic [2:0]       mode_i,
  input logic             clr_en_i,
  input logic             ext_clr_i,
  input logic [CNT_W-1:0] cmp_act,
  input logic             ref_o
);
  logic trig;
  logic seen_clr;

  always_comb trig = clr_en_i && ext_clr_i && (mode_i <= 3'd2);

  always_ff @(posedge clk) begin
    if (rst)       seen_clr <= 1'b0;
    else if (trig) seen_clr <= 1'b1;
    else if (ovf_i) seen_clr <= 1'b0;
  end

  a_r4_force_low: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b011) |=> !ref_o);
  a_r4_force_high: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 3'b100) |=> ref_o);
  a_r6_clear_low: assert property (@(posedge clk) disable iff (rst)
    trig |=> !ref_o);
  a_r7_hold_until_ovf: assert property (@(posedge clk) disable iff (rst)
    (seen_clr && !ovf_i && (mode_i <= 3'd2)) |=> !ref_o);
  a_r10_shadow_stable: assert property (@(posedge clk) disable iff (rst)
    !ovf_i |=> $stable(cmp_act));
endmodule

bind pwm_cmp_chan pwm_cmp_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ovf_i(ovf_i), .mode_i(mode_i),
  .clr_en_i(clr_en_i), .ext_clr_i(ext_clr_i), .cmp_act(cmp_act), .ref_o(ref_o)
);

// File: tb/pwm_cmp_chan_test.sv
module pwm_cmp_chan_test;
  localparam int CNT_W = 16;
  localparam int PER   = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] cnt_i = '0;
  logic             ovf_i = 1'b0;
  logic [CNT_W-1:0] cmp_i = '0;
  logic [2:0]       mode_i = 3'b100;
  logic             clr_en_i = 1'b0;
  logic             ext_clr_i = 1'b0;
  logic             ref_o;

  int n_chk = 0;
  int n_fail = 0;
  int c = 0;
  logic [CNT_W-1:0] m_cmp = '0;
  logic m_held = 1'b0;
  logic m_ref = 1'b0;

  pwm_cmp_chan #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .ovf_i(ovf_i), .cmp_i(cmp_i),
    .mode_i(mode_i), .clr_en_i(clr_en_i), .ext_clr_i(ext_clr_i), .ref_o(ref_o)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ref_o=%b expected %b (cnt=%0d mode=%b)", tag, act, exp, cnt_i, mode_i);
    end
  endtask

  // One counter step: drive at negedge, predict, check after the edge.
  task automatic step(input string tag);
    logic ov, clrbl, now, raw;
    logic [CNT_W-1:0] ce;
    @(negedge clk);
    cnt_i = CNT_W'(c);
    ov = (c == 0);
    ovf_i = ov;
    ce = ov ? cmp_i : m_cmp;
    clrbl = (mode_i <= 3'd2);
    now = clr_en_i && ext_clr_i && clrbl;
    case (mode_i)
      3'b001: raw = (cnt_i < ce);
      3'b010: raw = !(cnt_i < ce);
      3'b011: raw = 1'b0;
      3'b100: raw = 1'b1;
      default: raw = m_ref;
    endcase
    if (clrbl && (now || (m_held && !ov))) m_ref = 1'b0;
    else m_ref = raw;
    if (now) m_held = 1'b1; else if (ov) m_held = 1'b0;
    if (ov) m_cmp = cmp_i;
    @(posedge clk); #1;
    check(tag, ref_o, m_ref);
    c = (c == PER-1) ? 0 : c + 1;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic to_count(input int target, input string tag);
    while (c != target) step(tag);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", ref_o, 1'b0);
    @(negedge clk); rst = 1'b0;
    m_ref = 1'b0; m_held = 1'b0; m_cmp = '0; c = 0;
    mode_i = 3'b001; cmp_i = '0;
    step("R1 first cycle");
  endtask

  task automatic t_pwm_a;
    cmp_i = 16'd4; mode_i = 3'b001;
    to_count(0, "R2");
    run(2*PER, "R2 mid compare");
  endtask

  task automatic t_bounds;
    cmp_i = 16'd0; to_count(0, "R11"); run(PER, "R11 zero compare");
    cmp_i = 16'(PER + 2); run(PER, "R11 above max");
  endtask

  task automatic t_pwm_b;
    cmp_i = 16'd6; mode_i = 3'b010;
    to_count(0, "R3"); run(2*PER, "R3 inverse");
  endtask

  task automatic t_force;
    mode_i = 3'b011; run(4, "R4 force low");
    mode_i = 3'b100; run(4, "R4 force high");
  endtask

  task automatic t_frozen;
    mode_i = 3'b001; cmp_i = 16'd5; to_count(2, "R5 setup");
    mode_i = 3'b000; run(PER, "R5 frozen high");
    mode_i = 3'b001; to_count(7, "R5 setup");
    mode_i = 3'b110; run(PER, "R5 unused code");
  endtask

  task automatic t_clear;
    mode_i = 3'b001; cmp_i = 16'd8; clr_en_i = 1'b1;
    to_count(2, "R6 setup");
    ext_clr_i = 1'b1; step("R6 clear");
    ext_clr_i = 1'b0; to_count(0, "R7 held");
    run(PER, "R7 resume");
    to_count(8, "R7 setup");
    ext_clr_i = 1'b1; to_count(1, "R7 across ovf");
    ext_clr_i = 1'b0; to_count(0, "R7 held again");
    run(3, "R7 resume");
    mode_i = 3'b010; to_count(9, "R6 setup B");
    ext_clr_i = 1'b1; step("R6 clear B");
    ext_clr_i = 1'b0; run(PER, "R7 pwm B");
  endtask

  task automatic t_clr_disabled;
    mode_i = 3'b001; cmp_i = 16'd5; clr_en_i = 1'b0; ext_clr_i = 1'b1;
    run(2*PER, "R8 ignored");
    ext_clr_i = 1'b0;
  endtask

  task automatic t_clr_forced;
    clr_en_i = 1'b1; ext_clr_i = 1'b1;
    mode_i = 3'b100; run(PER, "R9 force high");
    ext_clr_i = 1'b0; mode_i = 3'b001; cmp_i = 16'd9;
    run(PER, "R9 no residue");
    clr_en_i = 1'b0;
  endtask

  task automatic t_shadow;
    mode_i = 3'b001; cmp_i = 16'd5; to_count(0, "R10 setup"); step("R10 load");
    to_count(3, "R10");
    cmp_i = 16'd2; to_count(0, "R10 old value kept");
    run(PER, "R10 new value");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_pwm_a();
    t_bounds();
    t_pwm_b();
    t_force();
    t_frozen();
    t_clear();
    t_clr_disabled();
    t_clr_forced();
    t_shadow();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule